// File: doc/BRIEF.md
# Edge-Detect Interrupt Capture Unit

This block watches the lower group of general-purpose I/O lines of a parallel I/O chip, three byte-wide ports of 24 lines by default, and records a transition on any line whose detector has been armed. Each line has two software settings: the direction of the transition it reacts to (rising or falling) and whether it is armed at all. Once a transition is seen, a sticky per-line flag records it. The flags stay set until the host clears them. The upper I/O lines of the chip are not connected here and never raise an event.

The host reaches the unit through a narrow byte-wide register port: a byte index, a write strobe, write data and combinational read data. The paged register bank in front of this block drives that port. A three-bit summary, with one bit per port, tells the host which flag byte holds something, so the interrupt handler can go straight to that byte. An active-high interrupt line is raised while any flag is set.

Top module: `edge_irq_capture`

## Requirements
- R1: After reset every direction, arm and flag byte reads 0x00, `pend_sum` is 0 and `irq_o` is low.
- R2: With the direction bit at 1 and the arm bit at 1, a low-to-high change on that line sets its flag bit. Line n of port p is bit n of byte p.
- R3: With the direction bit at 0, a high-to-low change on an armed line sets its flag bit, and a low-to-high change on that line leaves the flag at 0.
- R4: A line whose arm bit is 0 never sets its flag bit, whatever its pin does.
- R5: A flag bit stays at 1 after the pin returns to its earlier level, until the host clears it.
- R6: A write to a flag byte keeps the flag bits that are written as 1 and clears those written as 0, so writing 0x00 clears the whole byte.
- R7: Summary bit p (read at index 9, bits 2:0) is the OR of flag byte p, and bits 7:3 of that read are 0. The same bits appear on `pend_sum`.
- R8: `irq_o` is high exactly when any summary bit is set.
- R9: An edge that is detected in the same cycle as a host write to its flag byte wins: its flag bit ends set.
- R10: After a pin changes between clock edges, the flag bit is still clear after the second rising clock edge and is set after the third. Two edges go to the synchronizer and one to the flag register.
- R11: Register map: indices 0 to 2 hold the direction bytes for ports 0 to 2, indices 3 to 5 the arm bytes, indices 6 to 8 the flag bytes, and index 9 the summary. Direction and arm bytes read back what was written. Any other index reads 0x00, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 24 | Raw levels of the watched I/O lines, line 0 in bit 0 |
| reg_idx | input | 4 | Register byte index |
| reg_we | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx`, combinational |
| pend_sum | output | 3 | Per-port flag summary |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench times the latency to the exact clock edge. A design with one synchronizer stage too few or too many sets the flag one cycle early or late. A direction bit wired backwards is caught because a falling-only line is first driven high and must stay clear. The race between a clear and a fresh edge is placed on the very edge where the detector fires. A design that lets the clear win loses that event, while a neighbouring bit in the same byte must still be cleared. Partial clears with a mixed mask, unmapped indices and a half-armed port guard against a clear that wipes the whole byte, a decoder that aliases, and an arm mask that is applied to the wrong bits.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    RG_DIR,
    RG_ARM,
    RG_FLAG,
    RG_SUM,
    RG_NONE
  } reg_region_e;

  // Which register group a byte index falls into.
  function automatic reg_region_e region_of(input int idx, input int nports);
    if (idx < nports)          return RG_DIR;
    else if (idx < 2 * nports) return RG_ARM;
    else if (idx < 3 * nports) return RG_FLAG;
    else if (idx == 3 * nports) return RG_SUM;
    else                       return RG_NONE;
  endfunction

  // Port number inside a group (meaningful for the three byte groups).
  function automatic int port_of(input int idx, input int nports);
    return idx % nports;
  endfunction

  // Lines that saw an armed transition in the chosen direction.
  function automatic byte_t edge_hits(input byte_t dir, input byte_t arm,
                                      input byte_t now_lvl, input byte_t old_lvl);
    byte_t up, down;
    up   = now_lvl & ~old_lvl;
    down = ~now_lvl & old_lvl;
    return arm & ((dir & up) | (~dir & down));
  endfunction

  // Flag update: a host write masks the byte, and fresh hits always land.
  function automatic byte_t flag_next(input byte_t flag, input logic host_we,
                                      input byte_t wdata, input byte_t hit);
    byte_t kept;
    kept = host_we ? (flag & wdata) : flag;
    return kept | hit;
  endfunction

endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[s] <= '0;
        end else begin
          if (s == 0) stg[s] <= d_raw;
          else        stg[s] <= stg[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/ecu_port.sv
module ecu_port
  import edge_cap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t lvl,
  input  logic  dir_we,
  input  logic  arm_we,
  input  logic  flag_we,
  input  byte_t wdata,
  output byte_t dir_q,
  output byte_t arm_q,
  output byte_t flag_q,
  output byte_t hit
);

  byte_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      arm_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (arm_we) arm_q <= wdata;
    end
  end

  assign hit = edge_hits(dir_q, arm_q, lvl, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_next(flag_q, flag_we, wdata, hit);
  end

endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture
  import edge_cap_pkg::*;
#(
  parameter int NUM_PORTS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*BYTE_W-1:0] pin_lvl,
  input  logic [IDX_W-1:0]            reg_idx,
  input  logic                        reg_we,
  input  logic [BYTE_W-1:0]           reg_wdata,
  output logic [BYTE_W-1:0]           reg_rdata,
  output logic [NUM_PORTS-1:0]        pend_sum,
  output logic                        irq_o
);

  localparam int LINES = NUM_PORTS * BYTE_W;

  logic [LINES-1:0]     lvl_sync;
  logic [LINES-1:0]     hit_all;
  logic [LINES-1:0]     flag_all;
  logic [LINES-1:0]     arm_all;
  logic [NUM_PORTS-1:0] wr_dir, wr_arm, wr_flag;

  byte_t dir_b  [NUM_PORTS];
  byte_t arm_b  [NUM_PORTS];
  byte_t flag_b [NUM_PORTS];

  reg_region_e sel_region;
  int          sel_port;

  always_comb begin
    sel_region = region_of(int'(reg_idx), NUM_PORTS);
    sel_port   = port_of(int'(reg_idx), NUM_PORTS);
  end

  ecu_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_raw  (pin_lvl),
    .d_sync (lvl_sync)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      assign wr_dir[p]  = reg_we && (sel_region == RG_DIR)  && (sel_port == p);
      assign wr_arm[p]  = reg_we && (sel_region == RG_ARM)  && (sel_port == p);
      assign wr_flag[p] = reg_we && (sel_region == RG_FLAG) && (sel_port == p);

      ecu_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync[p*BYTE_W +: BYTE_W]),
        .dir_we  (wr_dir[p]),
        .arm_we  (wr_arm[p]),
        .flag_we (wr_flag[p]),
        .wdata   (reg_wdata),
        .dir_q   (dir_b[p]),
        .arm_q   (arm_b[p]),
        .flag_q  (flag_b[p]),
        .hit     (hit_all[p*BYTE_W +: BYTE_W])
      );

      assign flag_all[p*BYTE_W +: BYTE_W] = flag_b[p];
      assign arm_all[p*BYTE_W +: BYTE_W]  = arm_b[p];
      assign pend_sum[p] = |flag_b[p];
    end
  endgenerate

  assign irq_o = |pend_sum;

  always_comb begin
    reg_rdata = '0;
    if (sel_region == RG_SUM) begin
      reg_rdata = BYTE_W'(pend_sum);
    end else begin
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (sel_port == q) begin
          case (sel_region)
            RG_DIR:  reg_rdata = dir_b[q];
            RG_ARM:  reg_rdata = arm_b[q];
            RG_FLAG: reg_rdata = flag_b[q];
            default: reg_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/edge_irq_capture_chk.sv
module edge_irq_capture_chk
  import edge_cap_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int IDX_W     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [IDX_W-1:0]            reg_idx,
  input logic [BYTE_W-1:0]           reg_wdata,
  input logic [BYTE_W-1:0]           reg_rdata,
  input logic [NUM_PORTS-1:0]        pend_sum,
  input logic                        irq_o,
  input logic [NUM_PORTS*BYTE_W-1:0] hit_all,
  input logic [NUM_PORTS*BYTE_W-1:0] flag_all,
  input logic [NUM_PORTS*BYTE_W-1:0] arm_all,
  input logic [NUM_PORTS-1:0]        wr_flag
);

  localparam int SUM_IDX = 3 * NUM_PORTS;

  // R8
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_sum != '0));

  // R4
  hit_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_all & ~arm_all) == '0);

  // R2
  flag_set_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flag_all & ~$past(flag_all) & ~$past(hit_all)) == '0));

  // R7
  sum_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_idx) == SUM_IDX) |-> ((reg_rdata >> NUM_PORTS) == '0));

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_chk
      // R5
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag[p] |=> ((flag_all[p*BYTE_W +: BYTE_W] & $past(flag_all[p*BYTE_W +: BYTE_W]))
                         == $past(flag_all[p*BYTE_W +: BYTE_W])));
      // R6
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag[p] && reg_wdata == '0 && hit_all[p*BYTE_W +: BYTE_W] == '0)
        |=> (flag_all[p*BYTE_W +: BYTE_W] == '0));
      // R9
      clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag[p] && hit_all[p*BYTE_W +: BYTE_W] != '0)
        |=> ((flag_all[p*BYTE_W +: BYTE_W] & $past(hit_all[p*BYTE_W +: BYTE_W]))
             == $past(hit_all[p*BYTE_W +: BYTE_W])));
    end
  endgenerate

endmodule

bind edge_irq_capture edge_irq_capture_chk #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_idx   (reg_idx),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pend_sum  (pend_sum),
  .irq_o     (irq_o),
  .hit_all   (hit_all),
  .flag_all  (flag_all),
  .arm_all   (arm_all),
  .wr_flag   (wr_flag)
);

// File: tb/sim_edge_irq_capture.sv
`timescale 1ns/1ps
module sim_edge_irq_capture;

  localparam int DIR0 = 0, ARM0 = 3, FLG0 = 6, SUM = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic [3:0]  idx = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  pend;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  edge_irq_capture u0 (
    .clk (clk), .rst_n (rst_n), .pin_lvl (pins), .reg_idx (idx),
    .reg_we (we), .reg_wdata (wdata), .reg_rdata (rdata),
    .pend_sum (pend), .irq_o (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input int d);
    @(negedge clk);
    idx = 4'(i); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int i, output int v);
    @(negedge clk);
    idx = 4'(i);
    #0.5;
    v = int'(rdata);
  endtask

  task automatic set_pins(input logic [23:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset;
    int v;
    for (int i = 0; i < 9; i++) begin
      rd(i, v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 pend after reset", int'(pend), 0);
    chk("R1 irq after reset", int'(irq), 0);
  endtask

  task automatic t_map;
    int v;
    wr(DIR0 + 2, 8'hA5);
    wr(ARM0 + 1, 8'h3C);
    rd(DIR0 + 2, v); chk("R11 dir byte2 readback", v, 8'hA5);
    rd(ARM0 + 1, v); chk("R11 arm byte1 readback", v, 8'h3C);
    wr(12, 8'hFF);
    rd(12, v);       chk("R11 unmapped read", v, 0);
    rd(DIR0, v);     chk("R11 dir byte0 untouched", v, 0);
    rd(ARM0, v);     chk("R11 arm byte0 untouched", v, 0);
    wr(DIR0 + 2, 0);
    wr(ARM0 + 1, 0);
  endtask

  task automatic t_rise;
    wr(DIR0, 8'hFF);
    wr(ARM0, 8'h01);
    @(negedge clk);
    idx = 4'(FLG0);
    pins[0] = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R10 flag clear after two edges", int'(rdata), 0);
    @(posedge clk);
    #1 chk("R10 R2 flag set after third edge", int'(rdata), 8'h01);
  endtask

  task automatic t_fall;
    int v;
    wr(DIR0 + 1, 8'h00);
    wr(ARM0 + 1, 8'hFF);
    set_pins(pins | 24'h00FF00);
    rd(FLG0 + 1, v); chk("R3 rising ignored on falling line", v, 0);
    set_pins(pins & ~24'h000200);
    rd(FLG0 + 1, v); chk("R3 falling edge on line 9", v, 8'h02);
  endtask

  task automatic t_mask;
    int v;
    wr(DIR0 + 2, 8'hFF);
    wr(ARM0 + 2, 8'h0F);
    set_pins(pins | 24'hFF0000);
    rd(FLG0 + 2, v); chk("R4 only armed lines flagged", v, 8'h0F);
  endtask

  task automatic t_pending;
    int v;
    rd(SUM, v);      chk("R7 summary all ports", v, 8'h07);
    chk("R7 pend_sum port", int'(pend), 3'b111);
    chk("R8 irq high", int'(irq), 1);
    wr(FLG0 + 1, 0);
    rd(FLG0 + 1, v); chk("R6 write zero clears byte1", v, 0);
    rd(SUM, v);      chk("R7 summary after byte1 cleared", v, 8'h05);
  endtask

  task automatic t_sticky;
    int v;
    set_pins(pins & ~24'h000001);
    rd(FLG0, v);     chk("R5 flag stays after pin returns", v, 8'h01);
    set_pins(pins & ~24'hFF0000);
    rd(FLG0 + 2, v); chk("R5 byte2 stays after pins drop", v, 8'h0F);
  endtask

  task automatic t_partial;
    int v;
    wr(FLG0 + 2, 8'h05);
    rd(FLG0 + 2, v); chk("R6 partial clear keeps ones", v, 8'h05);
    wr(FLG0 + 2, 0);
    wr(FLG0, 0);
    rd(SUM, v);      chk("R7 summary empty", v, 0);
    chk("R8 irq low when nothing pending", int'(irq), 0);
  endtask

  task automatic t_race;
    int v;
    wr(ARM0, 8'h03);
    set_pins(pins | 24'h000002);
    rd(FLG0, v);     chk("R2 line1 preset", v, 8'h02);
    @(negedge clk);
    pins[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    idx = 4'(FLG0); wdata = 8'h00; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(FLG0, v);     chk("R9 new edge beats clear", v, 8'h01);
    chk("R8 irq after race", int'(irq), 1);
    wr(FLG0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_mask();
    t_pending();
    t_sticky();
    t_partial();
    t_race();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule